// File: doc/BRIEF.md
# Dual-Chamber Tracking Pacing Timer

This block times a dual-chamber tracking pacing mode. It counts millisecond ticks, watches atrial and ventricular sense pulses, and decides when to stimulate each chamber. An atrial event, sensed or paced, starts an AV delay. If no ventricular sense arrives in that delay, the block issues a tracked ventricular pace. A ventricular event starts a quiet period of URI ticks. During this period neither chamber is sensed. An atrial escape window follows, and it fills out the rest of the lower-rate interval.

The block has three programmable intervals: the lower-rate interval (LRI), the upper-rate interval (URI) and the AV delay (AVD). All three are counted in ticks. The first cycle after reset differs from the rest. In it the block waits up to a full LRI for a ventricular sense. After that the cycle runs quiet period, atrial window, AV delay, and repeats. The block shows its current phase and a sense-enable flag for each chamber, so the sensing front end can tell which pulses count.

Top module: `dualPaceTimer`

## Requirements
- R1: After reset the phase is 0, the ventricular sense enable is 1, the atrial sense enable is 0, and both pace strobes are 0. The phase codes are: 0 = initial ventricular wait, 1 = post-ventricular quiet period, 2 = atrial escape window, 3 = AV delay.
- R2: In phase 0 the block paces the ventricle on the LRI-th tick after reset, unless an enabled ventricular sense comes first.
- R3: A ventricular event, either an enabled ventricular sense or a ventricular pace, clears both sense enables and enters phase 1.
- R4: In phase 1, the URI-th tick sets the atrial sense enable and enters phase 2.
- R5: In phase 2 the window lasts LRI−AVD−URI ticks, or 1 tick when that difference is zero or negative. An atrial pace is issued when the window expires, unless an enabled atrial sense comes first.
- R6: An atrial event clears the atrial sense enable, sets the ventricular sense enable and enters phase 3.
- R7: In phase 3 the block issues a tracked ventricular pace on the AVD-th tick, unless an enabled ventricular sense comes first. After the first cycle, phase 0 is never entered again.
- R8: A sense pulse for a chamber whose enable is clear has no effect on phase, enables or pacing.
- R9: Each pace strobe is high for exactly one clock. The atrial and ventricular strobes are never high together. When an enabled sense and a window expiry fall in the same clock, the sense wins and no pace is issued.
- R10: A pace strobe rises on the clock edge that samples the expiring tick. A tick sampled on the same edge that enters a phase does not count toward that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-clock millisecond tick |
| atrSense | input | 1 | Atrial sense pulse |
| venSense | input | 1 | Ventricular sense pulse |
| lowerRateIvl | input | TW | LRI, in ticks |
| upperRateIvl | input | TW | URI, in ticks |
| avDelay | input | TW | AV delay, in ticks |
| atrPace | output | 1 | Atrial pace strobe |
| venPace | output | 1 | Ventricular pace strobe |
| atrSenseEn | output | 1 | Atrial sense enable |
| venSenseEn | output | 1 | Ventricular sense enable |
| phase | output | 2 | Current phase code |

## Verification
A pace strobe is due one clock edge after the tick that ends its window: it shows in the cycle after the edge that samples the L-th tick counted from phase entry. A sense changes the phase and the enables on the edge that samples it. The bench applies each tick and each sense on the falling edge, with senses only in cycles that carry no tick, except for one deliberate collision. A monitor samples 5 ns after every rising edge and stamps each strobe with the number of the tick that caused it. It then compares the strobe against a queue of (chamber, tick number) items that the driver computed from the programmed intervals. Phase and enable checks are made at falling edges, after the edge that took in the stimulus.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  typedef enum logic [1:0] {
    PH_INIT_V  = 2'd0,
    PH_QUIET   = 2'd1,
    PH_ATR_WIN = 2'd2,
    PH_AV_WAIT = 2'd3
  } phase_t;

  // strobes from control to the interval datapath
  typedef struct packed {
    logic   restart;
    phase_t sel;
  } tmrCtrl_t;
endpackage

// File: rtl/pacerIntervalPath.sv
module pacerIntervalPath
  import pacer_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          msTick,
  input  logic [TW-1:0] lowerRateIvl,
  input  logic [TW-1:0] upperRateIvl,
  input  logic [TW-1:0] avDelay,
  input  tmrCtrl_t      ctl,
  output logic          expire
);
  localparam int SW = TW + 2;
  localparam logic [TW-1:0] CNT_MAX = '1;

  logic [TW-1:0] tickCount;
  logic signed [SW-1:0] winDiff;
  logic [TW-1:0] atrWindow;
  logic [TW-1:0] limit;

  // atrial window = LRI - AVD - URI, floored at one tick
  always_comb begin
    winDiff = $signed({2'b00, lowerRateIvl}) - $signed({2'b00, avDelay})
            - $signed({2'b00, upperRateIvl});
    if (winDiff <= 0) atrWindow = TW'(1);
    else              atrWindow = winDiff[TW-1:0];
  end

  always_comb begin
    unique case (ctl.sel)
      PH_INIT_V:  limit = lowerRateIvl;
      PH_QUIET:   limit = upperRateIvl;
      PH_ATR_WIN: limit = atrWindow;
      default:    limit = avDelay;
    endcase
  end

  assign expire = msTick && (({1'b0, tickCount} + 1'b1) >= {1'b0, limit});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               tickCount <= '0;
    else if (ctl.restart)                    tickCount <= '0;
    else if (msTick && tickCount != CNT_MAX) tickCount <= tickCount + 1'b1;
  end
endmodule

// File: rtl/pacerSeqCtrl.sv
module pacerSeqCtrl
  import pacer_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     atrSense,
  input  logic     venSense,
  input  logic     expire,
  output tmrCtrl_t ctl,
  output logic     atrPace,
  output logic     venPace,
  output logic     atrSenseEn,
  output logic     venSenseEn,
  output phase_t   phase
);
  phase_t phaseNext;
  logic atrEvt, venEvt, atrPaceNext, venPaceNext, atrEnNext, venEnNext;

  assign atrEvt = atrSense && atrSenseEn && (phase == PH_ATR_WIN);
  assign venEvt = venSense && venSenseEn &&
                  (phase == PH_INIT_V || phase == PH_AV_WAIT);

  always_comb begin
    phaseNext   = phase;
    atrPaceNext = 1'b0;
    venPaceNext = 1'b0;
    atrEnNext   = atrSenseEn;
    venEnNext   = venSenseEn;
    unique case (phase)
      PH_INIT_V, PH_AV_WAIT: begin
        if (venEvt || expire) begin
          venPaceNext = !venEvt;
          phaseNext   = PH_QUIET;
          atrEnNext   = 1'b0;
          venEnNext   = 1'b0;
        end
      end
      PH_QUIET: begin
        if (expire) begin
          phaseNext = PH_ATR_WIN;
          atrEnNext = 1'b1;
        end
      end
      default: begin
        if (atrEvt || expire) begin
          atrPaceNext = !atrEvt;
          phaseNext   = PH_AV_WAIT;
          atrEnNext   = 1'b0;
          venEnNext   = 1'b1;
        end
      end
    endcase
  end

  assign ctl.restart = (phaseNext != phase);
  assign ctl.sel     = phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_INIT_V;
      atrPace    <= 1'b0;
      venPace    <= 1'b0;
      atrSenseEn <= 1'b0;
      venSenseEn <= 1'b1;
    end else begin
      phase      <= phaseNext;
      atrPace    <= atrPaceNext;
      venPace    <= venPaceNext;
      atrSenseEn <= atrEnNext;
      venSenseEn <= venEnNext;
    end
  end
endmodule

// File: rtl/dualPaceTimer.sv
module dualPaceTimer
  import pacer_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          msTick,
  input  logic          atrSense,
  input  logic          venSense,
  input  logic [TW-1:0] lowerRateIvl,
  input  logic [TW-1:0] upperRateIvl,
  input  logic [TW-1:0] avDelay,
  output logic          atrPace,
  output logic          venPace,
  output logic          atrSenseEn,
  output logic          venSenseEn,
  output logic [1:0]    phase
);
  tmrCtrl_t ctl;
  logic     expire;
  phase_t   phaseQ;

  pacerIntervalPath #(.TW(TW)) u_path (
    .clk(clk), .rstN(rstN), .msTick(msTick),
    .lowerRateIvl(lowerRateIvl), .upperRateIvl(upperRateIvl), .avDelay(avDelay),
    .ctl(ctl), .expire(expire)
  );

  pacerSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .atrSense(atrSense), .venSense(venSense),
    .expire(expire), .ctl(ctl), .atrPace(atrPace), .venPace(venPace),
    .atrSenseEn(atrSenseEn), .venSenseEn(venSenseEn), .phase(phaseQ)
  );

  assign phase = phaseQ;
endmodule

// File: rtl/dualPaceTimerChecker.sv
module dualPaceTimerChecker #(
  parameter int TW = 12
) (
  input logic          clk,
  input logic          rstN,
  input logic          msTick,
  input logic          atrSense,
  input logic          venSense,
  input logic [TW-1:0] avDelay,
  input logic          atrPace,
  input logic          venPace,
  input logic          atrSenseEn,
  input logic          venSenseEn,
  input logic [1:0]    phase
);
  logic [TW:0] avTicks;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                avTicks <= '0;
    else if (phase != 2'd3)   avTicks <= '0;
    else if (msTick)          avTicks <= avTicks + 1'b1;
  end

  AST_PACE_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(atrPace && venPace)); // R9
  AST_APACE_ONE: assert property (@(posedge clk) disable iff (!rstN) atrPace |=> !atrPace); // R9
  AST_VPACE_ONE: assert property (@(posedge clk) disable iff (!rstN) venPace |=> !venPace); // R9
  AST_VEVT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    venPace |-> (!atrSenseEn && !venSenseEn && phase == 2'd1)); // R3
  AST_AEVT_ENABLES: assert property (@(posedge clk) disable iff (!rstN)
    atrPace |-> (!atrSenseEn && venSenseEn && phase == 2'd3)); // R6
  AST_NO_INIT_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    (phase != 2'd0) |=> (phase != 2'd0)); // R7
  AST_AV_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd3) |-> (avTicks < ((avDelay == '0) ? {{TW{1'b0}}, 1'b1} : {1'b0, avDelay}))); // R7
  AST_ATR_DISCARD: assert property (@(posedge clk) disable iff (!rstN)
    (atrSense && !atrSenseEn && !msTick) |=> (phase == $past(phase) && !atrPace)); // R8
  AST_VEN_DISCARD: assert property (@(posedge clk) disable iff (!rstN)
    (venSense && !venSenseEn && !msTick) |=> (phase == $past(phase) && !venPace)); // R8
endmodule

bind dualPaceTimer dualPaceTimerChecker #(.TW(TW)) u_chk (
  .clk(clk), .rstN(rstN), .msTick(msTick), .atrSense(atrSense), .venSense(venSense),
  .avDelay(avDelay), .atrPace(atrPace), .venPace(venPace),
  .atrSenseEn(atrSenseEn), .venSenseEn(venSenseEn), .phase(phase)
);

// File: tb/test_dualPaceTimer.sv
`timescale 1ns/1ps
module test_dualPaceTimer;
  localparam int TW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0, atrSense = 1'b0, venSense = 1'b0;
  logic [TW-1:0] lri = 12'd40, uri = 12'd10, avd = 12'd8;
  logic atrPace, venPace, atrSenseEn, venSenseEn;
  logic [1:0] phase;

  int testsRun = 0, testsFailed = 0, tickNo = 0;
  bit finished = 0;

  typedef struct { bit isVen; int tick; } paceItem_t;
  paceItem_t expQ[$];

  always #10 clk = ~clk;  // 50 MHz

  dualPaceTimer #(.TW(TW)) i_dualPaceTimer (
    .clk(clk), .rstN(rstN), .msTick(msTick), .atrSense(atrSense), .venSense(venSense),
    .lowerRateIvl(lri), .upperRateIvl(uri), .avDelay(avd),
    .atrPace(atrPace), .venPace(venPace), .atrSenseEn(atrSenseEn),
    .venSenseEn(venSenseEn), .phase(phase)
  );

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d (tick %0d)", req, act, exp, tickNo);
    end
  endtask

  task automatic expectPace(input bit isVen, input int tick);
    paceItem_t it;
    it.isVen = isVen;
    it.tick  = tick;
    expQ.push_back(it);
  endtask

  task automatic oneTick(input bit withAtr);
    @(negedge clk);
    msTick = 1'b1;
    atrSense = withAtr;
    tickNo++;
    @(negedge clk);
    msTick = 1'b0;
    atrSense = 1'b0;
  endtask

  task automatic runTo(input int target);
    while (tickNo < target) oneTick(1'b0);
  endtask

  task automatic pulse(input bit isVen);
    @(negedge clk);
    if (isVen) venSense = 1'b1; else atrSense = 1'b1;
    @(negedge clk);
    venSense = 1'b0;
    atrSense = 1'b0;
  endtask

  // monitor: stamp every strobe with the tick that caused it
  always @(posedge clk) begin
    #5;
    if (rstN && !finished) begin
      if (atrPace && venPace) check("R9 both strobes", 1, 0);
      if (atrPace || venPace) begin
        if (expQ.size() == 0) begin
          check("R9 unexpected pace (ven)", int'(venPace), -1);
        end else begin
          paceItem_t it;
          it = expQ.pop_front();
          check("R10 pace chamber (1=ven)", int'(venPace), int'(it.isVen));
          check("R10 pace tick", tickNo, it.tick);
        end
      end
    end
  end

  task automatic finish();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 phase", phase, 0);
    check("R1 venSenseEn", venSenseEn, 1);
    check("R1 atrSenseEn", atrSenseEn, 0);
    check("R1 pace", int'(atrPace | venPace), 0);
    rstN = 1'b1;

    // R2 free-running initial window, R8 atrial pulse discarded
    expectPace(1, 40);
    runTo(5);
    pulse(0);
    check("R8 atrial ignored phase", phase, 0);
    check("R8 atrial ignored en", atrSenseEn, 0);
    runTo(40);
    check("R3 phase after vpace", phase, 1);
    check("R3 enables cleared", int'(atrSenseEn | venSenseEn), 0);

    // R4 quiet period, R5 window 22, R7 AV delay 8
    expectPace(0, 72);
    expectPace(1, 80);
    runTo(49);
    check("R4 still quiet", phase, 1);
    runTo(50);
    check("R4 window phase", phase, 2);
    check("R4 atrSenseEn", atrSenseEn, 1);
    runTo(85);
    pulse(1);  // ventricular sense in quiet period
    check("R8 ven ignored phase", phase, 1);
    expectPace(0, 112);
    runTo(90);
    check("R8 quiet not restarted", phase, 2);

    // R6 sensed atrial event, tracked ventricular pace
    runTo(100);
    pulse(0);
    check("R6 phase", phase, 3);
    check("R6 atrSenseEn", atrSenseEn, 0);
    check("R6 venSenseEn", venSenseEn, 1);
    void'(expQ.pop_back());  // atrial pace at 112 was inhibited
    expectPace(1, 108);
    expectPace(0, 140);

    // R3/R7 ventricular sense in AV delay inhibits the tracked pace
    runTo(143);
    pulse(1);
    check("R3 phase after vsense", phase, 1);
    check("R3 enables cleared by vsense", int'(atrSenseEn | venSenseEn), 0);
    expectPace(0, 175);
    expectPace(1, 183);
    runTo(183);
    check("R7 no return to phase 0", int'(phase != 0), 1);

    // R5 saturation: 40-8-35 < 0 gives a one-tick window
    uri = 12'd35;
    expectPace(0, 219);
    expectPace(1, 227);
    runTo(218);
    check("R5 window phase", phase, 2);
    runTo(227);

    // R9 sense and expiry in the same clock: sense wins
    expectPace(1, 271);
    runTo(262);
    check("R9 pre-collision phase", phase, 2);
    oneTick(1'b1);
    check("R9 sense beats expiry", phase, 3);
    runTo(275);
    check("R7 final phase", phase, 1);

    repeat (3) @(negedge clk);
    check("R10 all expected paces seen", expQ.size(), 0);
    finish();
  end
endmodule